// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, called A and B. Each side has its own capture register. Each register has its own capture strobe, and a rising strobe loads the register from its bus. When one direction is enabled, the driven bus shows one of two values: the live value of the opposite bus, passed straight through, or the register that holds what was last captured from that bus. Each direction has its own select. An active-low enable and a direction input decide which bus, if any, is driven. Each bus is split into separate input, output and output-enable ports so that the block can be synthesized.

The capture strobes are ordinary signals sampled in the system clock domain. Each capture unit is a two-state machine:

- EDGE_LOW means the strobe was low at the last sample.
- EDGE_HIGH means it was high.
- The transition EDGE_LOW to EDGE_HIGH (the strobe is seen high) is the capture event.
- The transition EDGE_HIGH to EDGE_LOW (the strobe is seen low) re-arms the unit.
- A self-loop in either state keeps the register unchanged.

The path decoder has three states:

- PATH_ISOLATE: the enable is high.
- PATH_B_TO_A: the enable is low and direction is low.
- PATH_A_TO_B: the enable is low and direction is high.

The decoder follows its inputs in the same cycle. Moving between any two of these states takes no clock.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst` is high at a clock edge, both capture registers clear to zero. A stored read after reset returns 0x00.
- R2: The A register loads `a_in` at the first clock edge where `cap_a` is sampled high after being sampled low. The new value is visible on the stored path after that edge.
- R3: The B register loads `b_in` under the same rule, using `cap_b`.
- R4: A register holds its value at every edge that is not a capture event. This includes edges where its strobe stays high while the bus changes.
- R5: Capture works the same way whatever the values of `oe_n`, `dir`, `sel_ab` and `sel_ba`. This includes the isolated state.
- R6: When `oe_n` is 1, `a_oe` and `b_oe` are both 0 and `a_out` and `b_out` are both 0x00.
- R7: When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. `a_out` carries B-side data, and `b_out` is 0x00.
- R8: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0. `b_out` carries A-side data, and `a_out` is 0x00.
- R9: A select at 0 picks live data, with no clock between them: `b_out` equals `a_in`, or `a_out` equals `b_in`. A select at 1 picks the register from the opposite side. `sel_ab` governs `b_out` and `sel_ba` governs `a_out`, independently of each other.
- R10: `a_oe` and `b_oe` are never 1 at the same time.
- R11: At reset release, each capture unit takes on the current strobe level. A strobe held high through reset therefore captures nothing until it has been seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0: drive A from the B side, 1: drive B from the A side |
| sel_ab | input | 1 | Source for `b_out`: 0 live `a_in`, 1 stored A register |
| sel_ba | input | 1 | Source for `a_out`: 0 live `b_in`, 1 stored B register |
| cap_a | input | 1 | A-side capture strobe, acts on its rising edge |
| cap_b | input | 1 | B-side capture strobe, acts on its rising edge |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Value driven onto bus A, 0 when not driven |
| a_oe | output | 1 | Bus A is being driven |
| b_out | output | W | Value driven onto bus B, 0 when not driven |
| b_oe | output | 1 | Bus B is being driven |

## Verification
The hardest case to reach is a capture that lands while its register cannot be seen. That happens when a strobe rises during isolation, or while the opposite direction is enabled. The loaded value only shows up later, once the path is switched to stored mode. The stimulus therefore loads distinct patterns under each of those control settings. Only afterwards does it turn the matching direction on with its select high, so that a capture that was gated or lost would read back the wrong value. A second hard case is a strobe that is held high across reset and across bus changes. The stimulus holds the strobe there and then drops and raises it, to show that only a fresh edge loads the register.

// File: rtl/bus_xcvr_pkg.sv
`timescale 1ns/1ps
package bus_xcvr_pkg;

    // Which bus, if any, is being driven
    typedef enum logic [1:0] {
        PATH_ISOLATE = 2'd0,
        PATH_B_TO_A  = 2'd1,
        PATH_A_TO_B  = 2'd2
    } path_e;

    // Last sampled level of a capture strobe
    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_e;

endpackage

// File: rtl/edge_cap_reg.sv
`timescale 1ns/1ps
module edge_cap_reg
    import bus_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    edge_e state_q;
    edge_e state_d;
    logic  load;

    // State register: on reset, take on the strobe level so that a held strobe is no edge (R11)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= cap ? EDGE_HIGH : EDGE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and capture decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            EDGE_LOW: begin
                if (cap) begin
                    state_d = EDGE_HIGH;
                    load    = 1'b1;
                end
            end
            EDGE_HIGH: begin
                if (!cap) begin
                    state_d = EDGE_LOW;
                end
            end
            default: begin
                state_d = EDGE_LOW;
            end
        endcase
    end

    // Data register
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/path_decode.sv
`timescale 1ns/1ps
module path_decode
    import bus_xcvr_pkg::*;
(
    input  logic  oe_n,
    input  logic  dir,
    output path_e mode,
    output logic  drive_a,
    output logic  drive_b
);

    always_comb begin
        if (oe_n) begin
            mode = PATH_ISOLATE;
        end else if (dir) begin
            mode = PATH_A_TO_B;
        end else begin
            mode = PATH_B_TO_A;
        end
    end

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (mode)
            PATH_ISOLATE: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
            PATH_B_TO_A: begin
                drive_a = 1'b1;
            end
            PATH_A_TO_B: begin
                drive_b = 1'b1;
            end
            default: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_mux.sv
`timescale 1ns/1ps
module lane_mux #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    // One identical slice per bit channel
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign y[i] = en & (use_stored ? stored[i] : live[i]);
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
module bus_xcvr_reg
    import bus_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] stored_a;
    logic [W-1:0] stored_b;
    path_e        mode;

    edge_cap_reg #(.W(W)) u_reg_a (
        .clk (clk),
        .rst (rst),
        .cap (cap_a),
        .d   (a_in),
        .q   (stored_a)
    );

    edge_cap_reg #(.W(W)) u_reg_b (
        .clk (clk),
        .rst (rst),
        .cap (cap_b),
        .d   (b_in),
        .q   (stored_b)
    );

    path_decode u_dec (
        .oe_n    (oe_n),
        .dir     (dir),
        .mode    (mode),
        .drive_a (a_oe),
        .drive_b (b_oe)
    );

    lane_mux #(.W(W)) u_mux_a (
        .en         (a_oe),
        .use_stored (sel_ba),
        .live       (b_in),
        .stored     (stored_b),
        .y          (a_out)
    );

    lane_mux #(.W(W)) u_mux_b (
        .en         (b_oe),
        .use_stored (sel_ab),
        .live       (a_in),
        .stored     (stored_a),
        .y          (b_out)
    );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
`timescale 1ns/1ps
module bus_xcvr_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         cap_a,
    input logic         cap_b,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] st_a,
    input logic [W-1:0] st_b
);

    p_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

    p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_a) |=> (st_a == $past(a_in)));

    p_cap_b_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_b) |=> (st_b == $past(b_in)));

    p_hold_a_r4: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_a) |=> $stable(st_a));

    p_hold_b_r4: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_b) |=> $stable(st_b));

    p_b2a_live_r7: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir && !sel_ba) |-> (a_oe && !b_oe && a_out == b_in));

    p_a2b_stored_r9: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir && sel_ab) |-> (b_oe && !a_oe && b_out == st_a));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .st_a   (stored_a),
    .st_b   (stored_b)
);

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst, oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    // Scoreboard: expected {a_oe, b_oe, a_out, b_out} plus requirement tag
    logic [2*W+1:0] exp_q[$];
    string          tag_q[$];
    int             checks   = 0;
    int             failures = 0;
    bit             done     = 0;

    // Independent model of the two capture registers
    logic [W-1:0] m_ra = '0, m_rb = '0;
    logic         m_pa = 1'b0, m_pb = 1'b0;

    task automatic step(input logic r, input logic en_n, input logic d,
                        input logic sab, input logic sba,
                        input logic ca, input logic cb,
                        input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input string tag, input bit chk);
        logic         eao, ebo;
        logic [W-1:0] ea, eb;
        @(negedge clk);
        rst = r; oe_n = en_n; dir = d; sel_ab = sab; sel_ba = sba;
        cap_a = ca; cap_b = cb; a_in = ai; b_in = bi;
        eao = !en_n && !d;
        ebo = !en_n && d;
        ea  = eao ? (sba ? m_rb : bi) : '0;
        eb  = ebo ? (sab ? m_ra : ai) : '0;
        if (chk) begin
            exp_q.push_back({eao, ebo, ea, eb});
            tag_q.push_back(tag);
        end
        // Model the following clock edge
        if (r) begin
            m_ra = '0; m_rb = '0;
        end else begin
            if (ca && !m_pa) m_ra = ai;
            if (cb && !m_pb) m_rb = bi;
        end
        m_pa = ca; m_pb = cb;
    endtask

    // Monitor: compares one result per cycle, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2*W+1:0] e;
                string          t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({a_oe, b_oe, a_out, b_out} !== e) begin
                    failures++;
                    $display("FAIL %s: actual a_oe=%0b b_oe=%0b a_out=%h b_out=%h expected a_oe=%0b b_oe=%0b a_out=%h b_out=%h",
                             t, a_oe, b_oe, a_out, b_out,
                             e[2*W+1], e[2*W], e[2*W-1:W], e[W-1:0]);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #20000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 / R11: reset with cap_a held high
        step(1, 1, 0, 0, 0, 1, 0, 8'h00, 8'h00, "R1", 0);
        step(1, 1, 0, 0, 0, 1, 0, 8'h11, 8'h22, "R6", 1);
        step(0, 0, 1, 1, 0, 1, 0, 8'hAA, 8'h00, "R1", 1);
        step(0, 0, 0, 0, 1, 1, 0, 8'hAB, 8'h00, "R1", 1);
        // R11: still high, bus changes, no capture
        step(0, 0, 1, 1, 0, 1, 0, 8'hAC, 8'h00, "R11", 1);
        step(0, 0, 1, 1, 0, 1, 0, 8'hAD, 8'h00, "R11", 1);
        // R2: drop then raise cap_a
        step(0, 0, 1, 1, 0, 0, 0, 8'h33, 8'h00, "R2", 1);
        step(0, 0, 1, 1, 0, 1, 0, 8'h5A, 8'h00, "R2", 1);
        step(0, 0, 1, 1, 0, 1, 0, 8'h77, 8'h00, "R2", 1);
        // R4: strobe stays high while bus changes
        step(0, 0, 1, 1, 0, 1, 0, 8'h01, 8'h00, "R4", 1);
        step(0, 0, 1, 1, 0, 0, 0, 8'h02, 8'h00, "R4", 1);
        // R9: live A to B, several patterns
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, 0, 1, 0, 0, 8'(8'h0F << i), 8'hFF, "R9", 1);
        // R8: A-to-B path, a_out zero
        step(0, 0, 1, 0, 0, 0, 0, 8'hE7, 8'h18, "R8", 1);
        // R3 and R5: capture B while isolated
        step(0, 1, 0, 1, 1, 0, 0, 8'h00, 8'h12, "R5", 1);
        step(0, 1, 1, 0, 1, 0, 1, 8'h00, 8'hC3, "R3", 1);
        step(0, 1, 0, 1, 0, 1, 1, 8'h9E, 8'h44, "R5", 1);
        // R7: show stored B on A; stored A on B after another mode
        step(0, 0, 0, 0, 1, 1, 1, 8'h00, 8'h55, "R7", 1);
        step(0, 0, 0, 0, 1, 0, 0, 8'h00, 8'h66, "R3", 1);
        step(0, 0, 1, 1, 1, 0, 0, 8'h00, 8'h66, "R5", 1);
        // R5: capture A while B-to-A enabled, stored/live split selects
        step(0, 0, 0, 1, 0, 1, 0, 8'h3C, 8'h81, "R5", 1);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h42, "R7", 1);
        step(0, 0, 1, 1, 0, 0, 0, 8'hF0, 8'h42, "R5", 1);
        // R9: independent selects, live B on A
        for (int i = 0; i < 4; i++)
            step(0, 0, 0, 1, 0, 0, 0, 8'hFF, 8'(8'h81 >> i), "R9", 1);
        // R10: toggle direction and enable
        for (int i = 0; i < 8; i++)
            step(0, i[2], i[0], i[1], ~i[1], 0, 0, 8'(i * 17), 8'(i * 29), "R10", 1);
        // R6: isolation with everything else high
        step(0, 1, 1, 1, 1, 1, 1, 8'hFF, 8'hFF, "R6", 1);
        // R1: reset again clears stored values
        step(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R1", 1);
        step(0, 0, 1, 1, 0, 0, 0, 8'hFF, 8'hFF, "R1", 1);
        step(0, 0, 0, 0, 1, 0, 0, 8'hFF, 8'hFF, "R1", 1);
        @(negedge clk);
        @(negedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule